// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-master SPI engine that a host controls through six byte-wide registers. Two configuration bytes set the SPI mode, the word length, the bit order, the serial clock rate, the slave-select behaviour and the interrupt routing. Four data bytes together form one 32-bit shift word. A transfer uses the low 8, 16, 24 or 32 bits of that word. The host fills the data bytes and then writes the top data byte. That write starts the transfer, and the host polls the busy flag until the transfer ends.

The bits received on MISO overwrite the transmitted bits in place, so the host reads the reply from the same data bytes. The slave select can follow the transfer automatically. It can also be held asserted by software, which allows multi-word transactions. A single shared interrupt input from the attached slaves is shown as a status bit and can be steered onto one of several interrupt request lines.

Top module: `spi_regmap_master`

## Requirements
- R1: After reset, every register reads 0x00, `sclk` is 0, `mosi` is 0, all `ss_n` lines are 1 and `irq` is 0.
- R2: The registers sit at these addresses: config byte A at 0, config byte B at 1, and data bytes D0 to D3 at 2 to 5 (D0 is bits 7:0 of the word, D3 is bits 31:24). Any write to address 5 starts a transfer. Config B bit 0 then reads 1 from the next read onward. It stays 1 for exactly 2·N·H clock cycles, and the transfer ends on the last serial clock edge.
- R3: Config A bits 5:4 hold the length code. Codes 0, 1, 2 and 3 shift exactly 8, 16, 24 and 32 bits on the low bits of the word.
- R4: Config A bit 7 (CPOL) is the level `sclk` holds whenever no transfer runs. Config A bit 6 (CPHA) sets the sampling edge. With CPHA 0, data is sampled on the first edge of each bit and changed on the second edge. With CPHA 1, data is changed on the first edge and sampled on the second.
- R5: Config B bit 2 set to 1 shifts the least significant bit first. Set to 0, it shifts the most significant used bit first.
- R6: When config A bit 3 is 0, the line `ss_n[k]` is low exactly while a transfer runs. Here k is config A bits 2:0. At most one select line is ever low.
- R7: When config A bit 3 is 1, `ss_n[k]` is low for as long as the bit stays set. A transfer ending does not release it.
- R8: When the transfer ends, the used bits of the word hold the received bits and the unused upper bytes are unchanged. The word then holds that value until the host writes it again.
- R9: Register writes are ignored while a transfer runs.
- R10: Config B bit 1 reads the `slave_int` input. When config B bit 3 is 1 and `slave_int` is 1, the line `irq[s]` is driven high, where s is config B bits 7:6. All other lines stay low, and all lines are low when bit 3 is 0.
- R11: Config B bits 5:4 select the half-period H of `sclk` in system clocks. The value is H = HALF_MIN·2^(3−code), so code 3 is the fastest rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered, one cycle after the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| slave_int | input | 1 | Shared slave interrupt, active high |
| irq | output | NUM_IRQ | Interrupt request lines |

## Verification
The hardest situation to reach is a host access that lands in the middle of a long transfer. The bench creates it by starting a 32-bit transfer at the slowest rate, which keeps the engine busy for 512 cycles. It then writes both config A and a data byte while the busy flag still reads 1, and checks afterwards that the configuration is unchanged and that the data byte holds the received bits. The bench also runs a behavioural slave in all four modes, with both bit orders and asymmetric patterns. This shows that the sample and change edges and the bit ordering are correct in both directions.

// File: rtl/spi_regmap_pkg.sv
package spi_regmap_pkg;
  localparam int WORD_BITS = 32;
  localparam int IDX_W     = $clog2(WORD_BITS);

  localparam logic [2:0] A_CFGA = 3'd0;
  localparam logic [2:0] A_CFGB = 3'd1;
  localparam logic [2:0] A_D0   = 3'd2;
  localparam logic [2:0] A_D1   = 3'd3;
  localparam logic [2:0] A_D2   = 3'd4;
  localparam logic [2:0] A_D3   = 3'd5;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [1:0] len;
    logic       man_sel;
    logic [2:0] sel;
  } cfg_a_t;

  typedef struct packed {
    logic [1:0] irq_sel;
    logic [1:0] rate;
    logic       irq_en;
    logic       lsb_first;
  } cfg_b_t;
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter  int HALF_MIN = 1,
  localparam int LIM_MAX  = HALF_MIN * 8,
  localparam int CW       = $clog2(LIM_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    lim  = CW'(HALF_MIN << (3 - int'(rate)));
    tick = run && (cnt == CW'(lim - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_word_shift.sv
module spi_word_shift #(
  parameter  int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  word,
  input  logic [IW-1:0] top_idx,
  input  logic          lsb_first,
  input  logic          in_bit,
  output logic          out_bit,
  output logic          follow_bit,
  output logic [W-1:0]  next_word
);
  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (i > int'(top_idx))
        next_word[i] = word[i];
      else if (lsb_first)
        next_word[i] = (i == int'(top_idx)) ? in_bit : word[(i + 1) % W];
      else
        next_word[i] = (i == 0) ? in_bit : word[(i + W - 1) % W];
    end
    out_bit    = lsb_first ? word[0] : word[top_idx];
    follow_bit = lsb_first ? word[1] : word[top_idx - 1'b1];
  end
endmodule

// File: rtl/spi_regmap_master.sv
module spi_regmap_master
  import spi_regmap_pkg::*;
#(
  parameter int HALF_MIN = 1,
  parameter int NUM_SS   = 8,
  parameter int NUM_IRQ  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic [2:0]         host_addr,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_SS-1:0]  ss_n,
  input  logic               slave_int,
  output logic [NUM_IRQ-1:0] irq
);
  localparam int W = WORD_BITS;

  cfg_a_t         ctl1;
  cfg_b_t         ctl2;
  logic           busy;
  logic           int_q;
  logic [W-1:0]   word;
  logic           rx_q;
  logic [5:0]     edge_cnt;
  logic           sclk_q, mosi_q;
  logic [7:0]     rdata_q;
  logic [NUM_IRQ-1:0] irq_q;

  logic           wr_ok, trig, tick, last_edge, in_bit;
  logic [W-1:0]   word_src, next_word;
  logic [IDX_W-1:0] top_idx;
  logic           out_bit, follow_bit;

  always_comb begin
    wr_ok     = host_wr && !busy;
    trig      = wr_ok && (host_addr == A_D3);
    top_idx   = {ctl1.len, 3'b111};
    last_edge = (edge_cnt == {ctl1.len, 4'hF});
    word_src  = trig ? {host_wdata, word[W-9:0]} : word;
    in_bit    = ctl1.cpha ? miso : rx_q;
  end

  spi_rate_div #(.HALF_MIN(HALF_MIN)) u_div (
    .clk(clk), .rst(rst), .run(busy), .rate(ctl2.rate), .tick(tick)
  );

  spi_word_shift #(.W(W)) u_shift (
    .word(word_src), .top_idx(top_idx), .lsb_first(ctl2.lsb_first),
    .in_bit(in_bit), .out_bit(out_bit), .follow_bit(follow_bit),
    .next_word(next_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl1     <= '0;
      ctl2     <= '0;
      busy     <= 1'b0;
      word     <= '0;
      rx_q     <= 1'b0;
      edge_cnt <= '0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
    end else if (wr_ok) begin
      case (host_addr)
        A_CFGA: ctl1 <= cfg_a_t'(host_wdata);
        A_CFGB: ctl2 <= cfg_b_t'(host_wdata[7:2]);
        A_D0:   word[7:0]   <= host_wdata;
        A_D1:   word[15:8]  <= host_wdata;
        A_D2:   word[23:16] <= host_wdata;
        A_D3:   word[31:24] <= host_wdata;
        default: ;
      endcase
      if (trig) begin
        busy     <= 1'b1;
        edge_cnt <= '0;
        mosi_q   <= out_bit;
      end
      sclk_q <= (host_addr == A_CFGA) ? host_wdata[7] : ctl1.cpol;
    end else if (busy) begin
      if (tick) begin
        sclk_q   <= ~sclk_q;
        edge_cnt <= edge_cnt + 1'b1;
        if (!edge_cnt[0]) begin
          if (!ctl1.cpha) rx_q   <= miso;
          else            mosi_q <= out_bit;
        end else begin
          word <= next_word;
          if (!ctl1.cpha && !last_edge) mosi_q <= follow_bit;
        end
        if (last_edge) busy <= 1'b0;
      end
    end else begin
      sclk_q <= ctl1.cpol;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q   <= 1'b0;
      irq_q   <= '0;
      rdata_q <= '0;
    end else begin
      int_q <= slave_int;
      for (int j = 0; j < NUM_IRQ; j++)
        irq_q[j] <= ctl2.irq_en && int_q && (ctl2.irq_sel == 2'(j));
      case (host_addr)
        A_CFGA:  rdata_q <= ctl1;
        A_CFGB:  rdata_q <= {ctl2, int_q, busy};
        A_D0:    rdata_q <= word[7:0];
        A_D1:    rdata_q <= word[15:8];
        A_D2:    rdata_q <= word[23:16];
        A_D3:    rdata_q <= word[31:24];
        default: rdata_q <= '0;
      endcase
    end
  end

  generate
    for (genvar k = 0; k < NUM_SS; k++) begin : g_sel
      assign ss_n[k] = !((ctl1.man_sel || busy) && (ctl1.sel == 3'(k)));
    end
  endgenerate

  assign sclk       = sclk_q;
  assign mosi       = mosi_q;
  assign irq        = irq_q;
  assign host_rdata = rdata_q;
endmodule

// File: rtl/spi_regmap_master_chk.sv
module spi_regmap_master_chk #(
  parameter int NUM_SS  = 8,
  parameter int NUM_IRQ = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               host_wr,
  input logic [2:0]         host_addr,
  input logic               busy,
  input logic               sclk,
  input logic [7:0]         cfg_a,
  input logic               irq_en,
  input logic [NUM_SS-1:0]  ss_n,
  input logic [NUM_IRQ-1:0] irq,
  input logic [31:0]        word
);
  p_ss_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ss_n));

  p_ss_auto_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && int'(cfg_a[2:0]) < NUM_SS) |-> !ss_n[cfg_a[2:0]]);

  p_sclk_rest_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !$past(host_wr)) |-> (sclk == cfg_a[7]));

  p_busy_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(host_wr && host_addr == 3'd5));

  p_word_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !$past(host_wr)) |-> $stable(word));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cfg_a));

  p_irq_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq));

  p_irq_enable_r10: assert property (@(posedge clk) disable iff (rst)
    (irq != '0) |-> $past(irq_en));
endmodule

bind spi_regmap_master spi_regmap_master_chk #(.NUM_SS(NUM_SS), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
  .busy(busy), .sclk(sclk), .cfg_a(ctl1), .irq_en(ctl2.irq_en),
  .ss_n(ss_n), .irq(irq), .word(word)
);

// File: tb/sim_spi_regmap_master.sv
`timescale 1ns/1ps
module sim_spi_regmap_master;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       sclk, mosi;
  logic       miso = 1'b0;
  logic [7:0] ss_n;
  logic       slave_int = 1'b0;
  logic [3:0] irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  spi_regmap_master u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ss_n(ss_n), .slave_int(slave_int), .irq(irq)
  );

  // behavioural slave
  logic        s_arm = 1'b0;
  logic        s_cpol, s_cpha, s_lsb;
  int          s_n, s_k;
  logic [31:0] s_tx, s_rx;

  function automatic int s_idx(int k);
    return s_lsb ? k : s_n - 1 - k;
  endfunction

  always @(posedge sclk or negedge sclk) begin
    if (s_arm) begin
      if (sclk == (s_cpol == s_cpha)) begin
        if (s_k < s_n) begin
          s_rx[s_idx(s_k)] = mosi;
          s_k = s_k + 1;
        end
      end else if (s_k < s_n) begin
        miso = s_tx[s_idx(s_k)];
      end
    end
  end

  // select-low cycle counter
  logic cnt_en = 1'b0;
  int   cur_sel = 0;
  int   sscnt = 0;
  always @(negedge clk) if (cnt_en && !ss_n[cur_sel]) sscnt++;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a;
    @(negedge clk); d = host_rdata;
  endtask

  task automatic do_xfer(input logic [7:0] c1, input logic [7:0] c2,
                         input logic [31:0] tx, input logic [31:0] stx, input bit poke);
    logic [7:0] v;
    logic [31:0] mask, exp_word;
    int n, lim;
    n   = 8 * (int'(c1[5:4]) + 1);
    lim = 1 << (3 - int'(c2[5:4]));
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    wr(3'd0, c1); wr(3'd1, c2);
    wr(3'd2, tx[7:0]); wr(3'd3, tx[15:8]); wr(3'd4, tx[23:16]);
    @(negedge clk);
    chk(sclk == c1[7], "R4 idle sclk before", 32'(sclk), 32'(c1[7]));
    s_cpol = c1[7]; s_cpha = c1[6]; s_lsb = c2[2]; s_n = n; s_k = 0;
    s_tx = stx; s_rx = '0; miso = stx[s_idx(0)]; s_arm = 1'b1;
    cur_sel = int'(c1[2:0]); sscnt = 0; cnt_en = 1'b1;
    wr(3'd5, tx[31:24]);
    rd(3'd1, v);
    chk(v[0] == 1'b1, "R2 busy after trigger", 32'(v[0]), 32'd1);
    if (poke) begin
      wr(3'd0, 8'hFF);
      wr(3'd2, 8'h00);
    end
    for (int g = 0; g < 4000; g++) begin
      rd(3'd1, v);
      if (!v[0]) break;
    end
    cnt_en = 1'b0; s_arm = 1'b0;
    if (!c1[3])
      chk(sscnt == 2 * n * lim, "R2 R11 R6 busy/select length", 32'(sscnt), 32'(2 * n * lim));
    chk(sclk == c1[7], "R4 idle sclk after", 32'(sclk), 32'(c1[7]));
    chk(s_k == n, "R3 bits shifted", 32'(s_k), 32'(n));
    chk(s_rx == (tx & mask), "R5 R4 slave received", s_rx, tx & mask);
    exp_word = (tx & ~mask) | (stx & mask);
    for (int b = 0; b < 4; b++) begin
      rd(3'(b + 2), v);
      chk(v == exp_word[8*b +: 8], "R8 R5 data byte", 32'(v), 32'(exp_word[8*b +: 8]));
    end
    if (poke) begin
      rd(3'd0, v);
      chk(v == c1, "R9 config write ignored while busy", 32'(v), 32'(c1));
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk(v == 8'h00, "R1 register reset", 32'(v), 32'h0);
    end
    chk(ss_n == 8'hFF, "R1 selects idle", 32'(ss_n), 32'hFF);
    chk(sclk == 1'b0 && mosi == 1'b0, "R1 sclk/mosi", {sclk, mosi}, 32'h0);
    chk(irq == 4'h0, "R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_manual();
    wr(3'd0, 8'h0D);
    @(negedge clk);
    chk(ss_n == 8'hDF, "R7 manual select asserted", 32'(ss_n), 32'hDF);
    do_xfer(8'h0D, 8'h30, 32'h0000_00C3, 32'h0000_0029, 1'b0);
    @(negedge clk);
    chk(ss_n == 8'hDF, "R7 manual select held after transfer", 32'(ss_n), 32'hDF);
    wr(3'd0, 8'h05);
    @(negedge clk);
    chk(ss_n == 8'hFF, "R7 manual select released", 32'(ss_n), 32'hFF);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(3'd1, 8'h88);
    slave_int = 1'b1;
    repeat (3) @(negedge clk);
    chk(irq == 4'b0100, "R10 irq routed", 32'(irq), 32'h4);
    rd(3'd1, v);
    chk(v[1] == 1'b1, "R10 status bit", 32'(v[1]), 32'd1);
    wr(3'd1, 8'h80);
    repeat (3) @(negedge clk);
    chk(irq == 4'b0000, "R10 irq disabled", 32'(irq), 32'h0);
    rd(3'd1, v);
    chk(v[1] == 1'b1, "R10 status with irq disabled", 32'(v[1]), 32'd1);
    wr(3'd1, 8'h48);
    repeat (3) @(negedge clk);
    chk(irq == 4'b0010, "R10 irq select 1", 32'(irq), 32'h2);
    slave_int = 1'b0;
    repeat (3) @(negedge clk);
    chk(irq == 4'b0000, "R10 irq follows input", 32'(irq), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    // mode 0, 24 bits, fastest rate, MSB first
    do_xfer(8'h26, 8'h30, 32'hA53C_96E1, 32'h005A_0F81, 1'b0);
    // mode 1, 8 bits, rate code 1, LSB first
    do_xfer(8'h42, 8'h14, 32'h7722_11B1, 32'h0000_006D, 1'b0);
    // mode 2, 16 bits, rate code 2, MSB first
    do_xfer(8'h90, 8'h20, 32'h1234_C05A, 32'h0000_8E13, 1'b0);
    // mode 3, 32 bits, slowest rate, LSB first
    do_xfer(8'hF7, 8'h04, 32'h8421_F00D, 32'h3C5A_96E7, 1'b0);
    t_manual();
    // host writes during a long transfer
    do_xfer(8'h31, 8'h00, 32'hDEAD_BEEF, 32'h1357_9BDF, 1'b1);
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule